// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block models the command interface of a parallel NOR flash that follows the widely used Intel-style command set, wrapped around a small on-chip word array. A host issues single-beat reads and writes carrying a byte address and a bus-wide data word. Writes are decoded as command bytes (low eight data bits) or as operands, depending on where a multi-beat sequence stands. Reads return array contents, a status byte, identification codes or query-table bytes, and which one depends only on the command sequence written before the read.

Requests use a valid/ready handshake. Reads are always accepted. A write is held off (ready low) while an internal sweep is filling an erased sector with ones. The host must then keep the write and its fields stable until ready rises. Each accepted read produces exactly one response beat on the next cycle. The response side has no back-pressure, so the host must take it when it appears. A write-protect input blocks every change to the array and sets error bits in the status register.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset, no response is pending, the block is in array mode, and a status read that follows command 0x70 returns 0x0000.
- R2: In array mode, writing 0x10 or 0x40 arms one program. The next write stores its data at the word it addresses, sets status bit 7 and returns to array mode.
- R3: Writing 0x20 fills every word of the addressed sector (word index with its low log2(sector words) bits cleared) with all ones, using one word per cycle. Status bit 7 reads 0 until that sweep is over. A following 0xD0 completes the sequence and leaves reads returning status.
- R4: In the beat after 0x20, a value of 0xFF, or any value other than 0xD0, returns the block to array mode.
- R5: Writing 0xE8 sets status bit 7 and starts a buffered write. The next write gives a count N. The following N+1 writes each store a word. After them, 0xD0 finishes, and reads return status the whole time.
- R6: Writing 0x60 followed by 0xD0 or 0x01 completes a lock sequence, and reads then return status. Any other second value returns the block to array mode.
- R7: Writing 0x50 clears all status bits and returns to array mode. Writing 0xFF or 0x00 as a command also returns to array mode.
- R8: While the current command is 0x20, 0x60, 0x70 or 0xE8, every read returns the status byte in bits 7:0, with zeros above.
- R9: After 0x90, word offset 0 reads the manufacturer code, offset 1 reads the device code, and every other offset reads 0.
- R10: After 0x98, a read returns the query byte at the word offset: 0x51, 0x52 and 0x59 at offsets 0x10, 0x11 and 0x12, and 0 from offset 0x40 upward. Only a 0xFF write leaves this mode.
- R11: The identification and query offset is address bits 7:0 shifted right by log2(bus bytes), so higher address bits do not matter.
- R12: With write-protect high, the array never changes. An erase attempt sets status bit 5, and a program or buffered-write attempt sets status bit 4.
- R13: A command byte that is not recognised returns the block to array mode.
- R14: Every accepted read gives one response on the next cycle and never any other. Ready is low only for a write arriving during an erase sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wprot | input | 1 | Write-protect: blocks array changes, sets error bits |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write (command/operand/data), 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data; command byte in bits 7:0 |
| rsp_valid | output | 1 | Read response valid, one cycle after an accepted read |
| rsp_data | output | DATA_W | Read response data |

## Verification
The bench targets the places where the read mux and the sequencer interact. Status polling during the erase sweep must show a clear ready bit; a design that shows ready at once would let the host confirm into a half-erased sector. It checks that 0xFF and a stray byte after 0x20 both fall back to array reads, and that a buffered count of N takes exactly N+1 data words; an off-by-one there would store the confirm byte as data or refuse it. Write-protected program, erase and buffered-write attempts are checked both for the right error bit and for untouched array words. ID and query reads at odd and high addresses expose a wrong offset shift.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_CLR_STAT = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUFWR    = 8'hE8;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_IDLE     = 8'h00;

  localparam int ST_READY    = 7;
  localparam int ST_ERR_ERS  = 5;
  localparam int ST_ERR_PROG = 4;

  typedef enum logic [1:0] {
    SEL_ARRAY,
    SEL_STATUS,
    SEL_IDENT,
    SEL_QUERY
  } rd_sel_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ARG,
    PH_DATA,
    PH_CONF
  } phase_e;

endpackage

// File: rtl/flash_seq.sv
`timescale 1ns/1ps
module flash_seq
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int WIDX_W  = 8,
  parameter int SECT_SH = 6,
  localparam int SECT_W = WIDX_W - SECT_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wprot,
  input  logic              sweep_busy,
  output logic              prog_we,
  output logic [WIDX_W-1:0] prog_idx,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_go,
  output logic [SECT_W-1:0] erase_sect,
  output rd_sel_e           rd_sel,
  output logic [7:0]        status_view
);

  logic [7:0]        cmd_q, cmd_d;
  phase_e            ph_q, ph_d;
  logic [7:0]        stat_q, stat_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic [7:0]        code;
  logic              to_array;

  assign code       = wr_data[7:0];
  assign prog_idx   = wr_idx;
  assign prog_data  = wr_data;
  assign erase_sect = wr_idx[WIDX_W-1:SECT_SH];

  always_comb begin
    cmd_d    = cmd_q;
    ph_d     = ph_q;
    stat_d   = stat_q;
    cnt_d    = cnt_q;
    prog_we  = 1'b0;
    erase_go = 1'b0;
    to_array = 1'b0;
    if (wr_fire) begin
      case (ph_q)
        PH_CMD: begin
          case (code)
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              cmd_d = code;
              ph_d  = PH_ARG;
            end
            OP_ERASE: begin
              if (wprot) stat_d[ST_ERR_ERS] = 1'b1;
              else       erase_go = 1'b1;
              stat_d[ST_READY] = 1'b1;
              cmd_d = code;
              ph_d  = PH_ARG;
            end
            OP_BUFWR: begin
              stat_d[ST_READY] = 1'b1;
              cmd_d = code;
              ph_d  = PH_ARG;
            end
            OP_STATUS, OP_IDENT: cmd_d = code;
            OP_CLR_STAT: begin
              stat_d   = '0;
              to_array = 1'b1;
            end
            default: to_array = 1'b1;
          endcase
        end
        PH_ARG: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              if (wprot) stat_d[ST_ERR_PROG] = 1'b1;
              else       prog_we = 1'b1;
              stat_d[ST_READY] = 1'b1;
              to_array = 1'b1;
            end
            OP_ERASE: begin
              if (code == OP_CONFIRM) begin
                ph_d = PH_CMD;
                stat_d[ST_READY] = 1'b1;
              end else begin
                to_array = 1'b1;
              end
            end
            OP_LOCK: begin
              if (code == OP_CONFIRM || code == OP_LOCK_ALT) begin
                ph_d = PH_CMD;
                stat_d[ST_READY] = 1'b1;
              end else begin
                to_array = 1'b1;
              end
            end
            OP_QUERY: begin
              if (code == OP_ARRAY) to_array = 1'b1;
            end
            OP_BUFWR: begin
              cnt_d = wr_data;
              ph_d  = PH_DATA;
            end
            default: to_array = 1'b1;
          endcase
        end
        PH_DATA: begin
          if (cmd_q == OP_BUFWR) begin
            if (wprot) stat_d[ST_ERR_PROG] = 1'b1;
            else       prog_we = 1'b1;
            stat_d[ST_READY] = 1'b1;
            if (cnt_q == '0) ph_d = PH_CONF;
            cnt_d = cnt_q - 1'b1;
          end else begin
            to_array = 1'b1;
          end
        end
        PH_CONF: begin
          if (cmd_q == OP_BUFWR && code == OP_CONFIRM) begin
            ph_d = PH_CMD;
            stat_d[ST_READY] = 1'b1;
          end else begin
            to_array = 1'b1;
          end
        end
        default: to_array = 1'b1;
      endcase
      if (to_array) begin
        cmd_d = OP_IDLE;
        ph_d  = PH_CMD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= OP_IDLE;
      ph_q   <= PH_CMD;
      stat_q <= '0;
      cnt_q  <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ph_q   <= ph_d;
      stat_q <= stat_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    case (cmd_q)
      OP_ERASE, OP_CLR_STAT, OP_LOCK, OP_STATUS, OP_BUFWR: rd_sel = SEL_STATUS;
      OP_IDENT: rd_sel = SEL_IDENT;
      OP_QUERY: rd_sel = SEL_QUERY;
      default:  rd_sel = SEL_ARRAY;
    endcase
  end

  assign status_view = {stat_q[ST_READY] & ~sweep_busy, stat_q[6:0]};

endmodule

// File: rtl/flash_store.sv
`timescale 1ns/1ps
module flash_store #(
  parameter int DATA_W  = 16,
  parameter int WIDX_W  = 8,
  parameter int SECT_SH = 6,
  localparam int SECT_W = WIDX_W - SECT_SH,
  localparam int DEPTH  = 1 << WIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [WIDX_W-1:0] prog_idx,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              erase_go,
  input  logic [SECT_W-1:0] erase_sect,
  input  logic              rd_en,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              sweep_busy
);

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [SECT_SH-1:0] sw_cnt_q;
  logic [SECT_W-1:0]  sw_sect_q;
  logic               busy_q;
  logic               we;
  logic [WIDX_W-1:0]  widx;
  logic [DATA_W-1:0]  wdat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      sw_cnt_q  <= '0;
      sw_sect_q <= '0;
    end else if (erase_go) begin
      busy_q    <= 1'b1;
      sw_cnt_q  <= '0;
      sw_sect_q <= erase_sect;
    end else if (busy_q) begin
      sw_cnt_q <= sw_cnt_q + 1'b1;
      if (&sw_cnt_q) busy_q <= 1'b0;
    end
  end

  assign we   = busy_q | prog_we;
  assign widx = busy_q ? {sw_sect_q, sw_cnt_q} : prog_idx;
  assign wdat = busy_q ? {DATA_W{1'b1}} : prog_data;

  always_ff @(posedge clk) begin
    if (we)    mem[widx] <= wdat;
    if (rd_en) rd_data   <= mem[rd_idx];
  end

  assign sweep_busy = busy_q;

endmodule

// File: rtl/flash_qrom.sv
`timescale 1ns/1ps
module flash_qrom #(
  parameter int OFF_W      = 7,
  parameter int QLEN       = 64,
  parameter int TOTAL_LOG2 = 9,
  parameter int NUM_SECT   = 4,
  parameter int SECT_BYTES = 128
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] off,
  output logic [7:0]       q_byte
);

  function automatic logic [7:0] entry(input int o);
    logic [7:0] v;
    v = 8'h00;
    if (o < QLEN) begin
      case (o)
        'h10: v = 8'h51;
        'h11: v = 8'h52;
        'h12: v = 8'h59;
        'h13: v = 8'h01;
        'h15: v = 8'h31;
        'h1B: v = 8'h45;
        'h1C: v = 8'h55;
        'h27: v = 8'(TOTAL_LOG2);
        'h28: v = 8'h01;
        'h2C: v = 8'h01;
        'h2D: v = 8'(NUM_SECT - 1);
        'h2E: v = 8'((NUM_SECT - 1) >> 8);
        'h2F: v = 8'(SECT_BYTES >> 8);
        'h30: v = 8'(SECT_BYTES >> 16);
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rd_en) q_byte <= entry(int'(off));
  end

endmodule

// File: rtl/flash_cmd_top.sv
`timescale 1ns/1ps
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int              DATA_W  = 16,
  parameter int              WIDX_W  = 8,
  parameter int              SECT_SH = 6,
  parameter logic [DATA_W-1:0] MFR_ID = 'h0089,
  parameter logic [DATA_W-1:0] DEV_ID = 'h0018,
  parameter int              QLEN    = 64,
  parameter int              ADDR_W  = WIDX_W + $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wprot,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int BUS_SH     = $clog2(DATA_W / 8);
  localparam int OFF_W      = 8 - BUS_SH;
  localparam int SECT_W     = WIDX_W - SECT_SH;
  localparam int SECT_BYTES = (1 << SECT_SH) << BUS_SH;

  logic              sweep_busy;
  logic              prog_we;
  logic [WIDX_W-1:0] prog_idx;
  logic [DATA_W-1:0] prog_data;
  logic              erase_go;
  logic [SECT_W-1:0] erase_sect;
  rd_sel_e           rd_sel;
  logic [7:0]        status_view;
  logic [DATA_W-1:0] arr_data;
  logic [7:0]        q_byte;

  logic              rd_fire, wr_fire;
  logic [WIDX_W-1:0] word_idx;
  logic [OFF_W-1:0]  off;

  rd_sel_e           sel_q;
  logic [7:0]        stat_snap_q;
  logic [DATA_W-1:0] id_q;
  logic              rsp_q;

  assign word_idx = req_addr[ADDR_W-1:BUS_SH];
  assign off      = req_addr[7:BUS_SH];

  generate
    if (BUS_SH > 0) begin : g_lane
      logic unused_lane_bits;
      assign unused_lane_bits = ^req_addr[BUS_SH-1:0];
    end
  endgenerate

  assign req_ready = ~(req_write & sweep_busy);
  assign rd_fire   = req_valid & ~req_write;
  assign wr_fire   = req_valid & req_write & ~sweep_busy;

  flash_seq #(
    .DATA_W (DATA_W),
    .WIDX_W (WIDX_W),
    .SECT_SH(SECT_SH)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_idx     (word_idx),
    .wr_data    (req_wdata),
    .wprot      (wprot),
    .sweep_busy (sweep_busy),
    .prog_we    (prog_we),
    .prog_idx   (prog_idx),
    .prog_data  (prog_data),
    .erase_go   (erase_go),
    .erase_sect (erase_sect),
    .rd_sel     (rd_sel),
    .status_view(status_view)
  );

  flash_store #(
    .DATA_W (DATA_W),
    .WIDX_W (WIDX_W),
    .SECT_SH(SECT_SH)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_we   (prog_we),
    .prog_idx  (prog_idx),
    .prog_data (prog_data),
    .erase_go  (erase_go),
    .erase_sect(erase_sect),
    .rd_en     (rd_fire),
    .rd_idx    (word_idx),
    .rd_data   (arr_data),
    .sweep_busy(sweep_busy)
  );

  flash_qrom #(
    .OFF_W     (OFF_W),
    .QLEN      (QLEN),
    .TOTAL_LOG2(WIDX_W + BUS_SH),
    .NUM_SECT  (1 << SECT_W),
    .SECT_BYTES(SECT_BYTES)
  ) i_qrom (
    .clk   (clk),
    .rd_en (rd_fire),
    .off   (off),
    .q_byte(q_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q       <= 1'b0;
      sel_q       <= SEL_ARRAY;
      stat_snap_q <= '0;
      id_q        <= '0;
    end else begin
      rsp_q <= rd_fire;
      if (rd_fire) begin
        sel_q       <= rd_sel;
        stat_snap_q <= status_view;
        if (off == OFF_W'(0))      id_q <= MFR_ID;
        else if (off == OFF_W'(1)) id_q <= DEV_ID;
        else                       id_q <= '0;
      end
    end
  end

  assign rsp_valid = rsp_q;

  always_comb begin
    case (sel_q)
      SEL_STATUS: rsp_data = {{(DATA_W-8){1'b0}}, stat_snap_q};
      SEL_IDENT:  rsp_data = id_q;
      SEL_QUERY:  rsp_data = {{(DATA_W-8){1'b0}}, q_byte};
      default:    rsp_data = arr_data;
    endcase
  end

endmodule

// File: rtl/flash_cmd_chk.sv
`timescale 1ns/1ps
module flash_cmd_chk #(
  parameter int SECT_WORDS = 64,
  localparam int CW = $clog2(SECT_WORDS) + 2
) (
  input logic clk,
  input logic rst_n,
  input logic wprot,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic rsp_valid,
  input logic sweep_busy,
  input logic prog_we
);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          run_cnt <= '0;
    else if (sweep_busy) run_cnt <= run_cnt + 1'b1;
    else                 run_cnt <= '0;
  end

  // R14
  read_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R14
  rsp_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  // R14
  stall_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> sweep_busy);

  // R12
  wp_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wprot |-> !prog_we);

  // R3
  sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sweep_busy) |-> run_cnt == CW'(SECT_WORDS));

  // R3
  no_prog_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> !prog_we);

endmodule

bind flash_cmd_top flash_cmd_chk #(.SECT_WORDS(1 << SECT_SH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wprot     (wprot),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .sweep_busy(sweep_busy),
  .prog_we   (prog_we)
);

// File: tb/test_flash_cmd_top.sv
`timescale 1ns/1ps
module test_flash_cmd_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wprot = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_mem [256];
  logic [15:0] got;

  always #2 clk = ~clk;

  flash_cmd_top i_flash_cmd_top (
    .clk(clk), .rst_n(rst_n), .wprot(wprot),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [15:0] exp_id(input int o);
    if (o == 0) return 16'h0089;
    if (o == 1) return 16'h0018;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] exp_query(input int o);
    if (o == 'h10) return 16'h0051;
    if (o == 'h11) return 16'h0052;
    if (o == 'h12) return 16'h0059;
    return 16'h0000;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R14 response beat", {15'd0, rsp_valid}, 16'd1);
    d = rsp_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R14 watchdog: actual hung expected done");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 no response after reset", {15'd0, rsp_valid}, 16'd0);
    wr(9'h000, 16'h0070);
    rd(9'h000, got); chk("R1 status after reset", got, 16'h0000);
    wr(9'h000, 16'h00FF);

    // R3: erase sector 0 with confirm, ready low during sweep, write stalled
    wr(9'h000, 16'h0020);
    rd(9'h000, got); chk("R3 ready low in sweep", got, 16'h0000);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 9'h000; req_wdata = 16'h00D0;
    #1;
    chk("R14 ready low for write in sweep", {15'd0, req_ready}, 16'd0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    // R8: status mode after confirmed erase
    rd(9'h00A, got); chk("R8 status after erase confirm", got, 16'h0080);
    wr(9'h000, 16'h00FF);
    rd(9'h00A, got); chk("R3 erased word", got, 16'hFFFF);
    rd(9'h07E, got); chk("R3 last word of sector", got, 16'hFFFF);

    // R4: abort with 0xFF after erase command
    wr(9'h000, 16'h0020);
    wr(9'h000, 16'h00FF);
    rd(9'h00A, got); chk("R4 array after 0xFF abort", got, 16'hFFFF);

    // R2: both program opcodes
    wr(9'h006, 16'h0040); wr(9'h006, 16'hA5C3);
    rd(9'h006, got); chk("R2 program 0x40", got, 16'hA5C3);
    wr(9'h008, 16'h0010); wr(9'h008, 16'h5A5A);
    rd(9'h008, got); chk("R2 program 0x10", got, 16'h5A5A);

    // R4: stray value after erase command, R13 style fallback
    wr(9'h084, 16'h0040); wr(9'h084, 16'h1234);
    rd(9'h084, got); chk("R2 program sector 1", got, 16'h1234);
    wr(9'h084, 16'h0020);
    wr(9'h084, 16'h0033);
    rd(9'h084, got); chk("R4 array after stray value", got, 16'hFFFF);

    // R5: buffered write, count 2 -> three words
    wr(9'h010, 16'h00E8);
    wr(9'h010, 16'h0002);
    wr(9'h010, 16'hBEEF);
    wr(9'h012, 16'h0F0F);
    wr(9'h014, 16'h7001);
    rd(9'h010, got); chk("R5 status during buffer", got, 16'h0080);
    wr(9'h010, 16'h00D0);
    rd(9'h010, got); chk("R5 status after confirm", got, 16'h0080);
    wr(9'h000, 16'h00FF);
    rd(9'h010, got); chk("R5 word 0", got, 16'hBEEF);
    rd(9'h012, got); chk("R5 word 1", got, 16'h0F0F);
    rd(9'h014, got); chk("R5 word 2", got, 16'h7001);

    // R6: lock sequences
    wr(9'h000, 16'h0060); wr(9'h000, 16'h0001);
    rd(9'h006, got); chk("R6 lock done status", got, 16'h0080);
    wr(9'h000, 16'h00FF);
    wr(9'h000, 16'h0060); wr(9'h000, 16'h00D0);
    rd(9'h006, got); chk("R6 unlock done status", got, 16'h0080);
    wr(9'h000, 16'h00FF);
    wr(9'h000, 16'h0060); wr(9'h000, 16'h0055);
    rd(9'h006, got); chk("R6 bad second value", got, 16'hA5C3);

    // R7: clear status and idle commands
    wr(9'h000, 16'h0050);
    rd(9'h006, got); chk("R7 array after clear", got, 16'hA5C3);
    wr(9'h000, 16'h0070);
    rd(9'h006, got); chk("R7 status cleared", got, 16'h0000);
    wr(9'h000, 16'h0000);
    rd(9'h006, got); chk("R7 0x00 to array", got, 16'hA5C3);

    // R9, R11: identification
    wr(9'h000, 16'h0090);
    rd(9'h000, got); chk("R9 manufacturer", got, exp_id(0));
    rd(9'h002, got); chk("R9 device", got, exp_id(1));
    rd(9'h004, got); chk("R9 other offset", got, exp_id(2));
    rd(9'h003, got); chk("R11 odd byte address", got, exp_id(1));
    rd(9'h100, got); chk("R11 high address bit", got, exp_id(0));
    wr(9'h000, 16'h00FF);

    // R10: query
    wr(9'h000, 16'h0098);
    rd(9'h020, got); chk("R10 Q", got, exp_query('h10));
    rd(9'h022, got); chk("R10 R", got, exp_query('h11));
    rd(9'h124, got); chk("R10 Y via R11 wrap", got, exp_query('h12));
    rd(9'h080, got); chk("R10 past table", got, exp_query('h40));
    wr(9'h000, 16'h0012);
    rd(9'h020, got); chk("R10 stays in query", got, exp_query('h10));
    wr(9'h000, 16'h00FF);
    rd(9'h006, got); chk("R10 leaves on 0xFF", got, 16'hA5C3);

    // R13: unknown command
    wr(9'h000, 16'h0070);
    wr(9'h000, 16'h00AB);
    rd(9'h006, got); chk("R13 unknown to array", got, 16'hA5C3);

    // R12: write protect
    wprot = 1'b1;
    wr(9'h000, 16'h0050);
    wr(9'h006, 16'h0040); wr(9'h006, 16'h1111);
    wr(9'h000, 16'h0070);
    rd(9'h000, got); chk("R12 program error bit", got, 16'h0090);
    wr(9'h000, 16'h00FF);
    rd(9'h006, got); chk("R12 program blocked", got, 16'hA5C3);
    wr(9'h000, 16'h0050);
    wr(9'h000, 16'h0020);
    rd(9'h000, got); chk("R12 erase error bit", got, 16'h00A0);
    wr(9'h000, 16'h00FF);
    rd(9'h006, got); chk("R12 erase blocked", got, 16'hA5C3);
    wr(9'h000, 16'h0050);
    wr(9'h006, 16'h00E8); wr(9'h006, 16'h0000);
    wr(9'h006, 16'h2222); wr(9'h006, 16'h00D0);
    rd(9'h000, got); chk("R12 buffer error bit", got, 16'h0090);
    wr(9'h000, 16'h00FF);
    rd(9'h006, got); chk("R12 buffer blocked", got, 16'hA5C3);
    wprot = 1'b0;

    // R2 random programs in sector 2 after erasing it (R3)
    wr(9'h100, 16'h0020); wr(9'h100, 16'h00D0); wr(9'h100, 16'h00FF);
    for (int i = 128; i < 192; i++) exp_mem[i] = 16'hFFFF;
    for (int n = 0; n < 40; n++) begin
      int idx;
      logic [15:0] d;
      idx = 128 + int'($urandom % 64);
      d = 16'($urandom);
      wr(9'(idx * 2), ($urandom % 2 == 0) ? 16'h0010 : 16'h0040);
      wr(9'(idx * 2), d);
      exp_mem[idx] = d;
      rd(9'(idx * 2), got); chk("R2 random program", got, exp_mem[idx]);
    end
    for (int i = 128; i < 192; i++) begin
      rd(9'(i * 2), got); chk("R2 R3 sector 2 readback", got, exp_mem[i]);
    end

    report();
  end

endmodule